// File: doc/BRIEF.md
# Five-Wire Audio Link Frame Sequencer

This block is the controller end of a five-wire, time-multiplexed audio codec link. The codec supplies the bit clock, and the whole block runs on that clock. The block produces the frame sync and drives an active-low reset toward the codec. It shifts one outgoing word per time slot onto the serial output line and collects one incoming word per slot from the serial input line. A frame is 256 bit clocks long, about 21 us at 12.288 MHz, which gives a 48 kHz frame rate. Each frame holds a 16-bit tag slot followed by twelve 20-bit data slots.

On the parallel side, a flat vector carries the thirteen outgoing words. Slot k occupies bits [k*20 +: 20], and the tag uses only bits [15:0] of the slot 0 field. A second flat vector with the same layout returns the captured words. A one-cycle strobe marks when a complete frame of captured words is ready.

The sequencing is a four-state machine:
- HOLD keeps the codec in reset.
- LEAD is a single bit time in which sync is high before the first frame.
- TAG shifts the tag slot.
- SLOT shifts data slots 1 to 12.

The transitions are:
- HOLD to LEAD, after RST_CYCLES bit clocks.
- LEAD to TAG.
- TAG to SLOT, after tag bit 15.
- SLOT to SLOT, at the end of slots 1 to 11, with the slot index incremented.
- SLOT to TAG, after slot 12 bit 19, so frames run back to back.

Top module: `aclink_seq`

## Requirements
- R1: While rst_n is low, sdout, sync, codec_rst_n and frame_done are 0 and every bit of rx_words is 0.
- R2: After rst_n rises, codec_rst_n stays low for the first RST_CYCLES (16) rising bit clock edges. It goes high at edge RST_CYCLES and stays high until the next reset.
- R3: Each frame is 256 bit clocks long, so the rising edges of sync are exactly 256 bit clocks apart.
- R4: sync goes high one bit time before tag bit 0 and stays high for 16 bit times. Before the first frame, that lead-in bit is a dedicated bit time with sdout at 0.
- R5: The tag slot sends tx_words[15:0] most significant bit first. sdout changes only on rising bit clock edges, and tx_words[19:16] has no effect on sdout.
- R6: Data slot k (1 to 12) sends tx_words[k*20 +: 20] most significant bit first. The word is taken at the rising edge that begins the slot.
- R7: sdin is sampled on falling bit clock edges. The captured tag appears in rx_words[15:0] with rx_words[19:16] at 0, and data slot k appears in rx_words[k*20 +: 20].
- R8: frame_done is high for exactly one bit clock, during bit 0 of the following frame. While it is high, rx_words holds all 13 words of the frame that just ended. No strobe occurs for the first frame's predecessor, and no strobe occurs for a frame that reset cut short.
- R9: A reset in the middle of a frame immediately returns sdout, sync and codec_rst_n to 0 and clears the captured words. The full hold, lead-in and frame sequence then restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the codec |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_words | input | 260 | Outgoing words, slot k at [k*20 +: 20], tag in [15:0] |
| sdin | input | 1 | Serial data from the codec |
| sdout | output | 1 | Serial data to the codec |
| sync | output | 1 | Frame sync |
| codec_rst_n | output | 1 | Active-low reset to the codec |
| rx_words | output | 260 | Captured words, same layout as tx_words |
| frame_done | output | 1 | One-cycle strobe: rx_words holds a full frame |

## Verification
Several frames are run back to back, each with a different pattern:
- Rising per-slot counts separate the slot indices, so a wrong slot order or a wrong word select is caught.
- Alternating 0xAAAAA/0x55555 words expose bit-order and off-by-one shift faults.
- A walking single bit pins down the alignment of each slot boundary.
- All-ones words show whether the upper bits of the tag field are masked.

Non-zero tag upper bits in both directions confirm that those bits are ignored. Finally, a reset in the middle of a frame, followed by a fresh start, separates true restart behaviour from a counter that merely resumes.

// File: rtl/aclink_pkg.sv
package aclink_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_LEAD = 2'd1,
        ST_TAG  = 2'd2,
        ST_SLOT = 2'd3
    } link_state_t;

endpackage

// File: rtl/aclink_timer.sv
module aclink_timer
    import aclink_pkg::*;
#(
    parameter int TAG_W      = 16,
    parameter int SLOT_W     = 20,
    parameter int N_DATA     = 12,
    parameter int RST_CYCLES = 16,
    localparam int MAX_W      = (SLOT_W > TAG_W) ? SLOT_W : TAG_W,
    localparam int BIT_W      = $clog2(MAX_W),
    localparam int SLOT_IDX_W = $clog2(N_DATA + 1),
    localparam int HOLD_W     = $clog2(RST_CYCLES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output link_state_t           state_q,
    output logic [SLOT_IDX_W-1:0] slot_q,
    output logic [BIT_W-1:0]      bit_q,
    output link_state_t           state_n,
    output logic [SLOT_IDX_W-1:0] slot_n,
    output logic [BIT_W-1:0]      bit_n,
    output logic                  sync,
    output logic                  codec_rst_n
);

    logic [HOLD_W-1:0] hold_q;
    logic [HOLD_W-1:0] hold_n;

    // next-position decode
    always_comb begin
        state_n = state_q;
        slot_n  = slot_q;
        bit_n   = bit_q;
        hold_n  = hold_q;
        unique case (state_q)
            ST_HOLD: begin
                if (hold_q == HOLD_W'(RST_CYCLES - 1)) begin
                    state_n = ST_LEAD;
                    hold_n  = '0;
                end else begin
                    hold_n = hold_q + 1'b1;
                end
            end
            ST_LEAD: begin
                state_n = ST_TAG;
                slot_n  = '0;
                bit_n   = '0;
            end
            ST_TAG: begin
                if (bit_q == BIT_W'(TAG_W - 1)) begin
                    state_n = ST_SLOT;
                    slot_n  = SLOT_IDX_W'(1);
                    bit_n   = '0;
                end else begin
                    bit_n = bit_q + 1'b1;
                end
            end
            ST_SLOT: begin
                if (bit_q == BIT_W'(SLOT_W - 1)) begin
                    bit_n = '0;
                    if (slot_q == SLOT_IDX_W'(N_DATA)) begin
                        state_n = ST_TAG;
                        slot_n  = '0;
                    end else begin
                        slot_n = slot_q + 1'b1;
                    end
                end else begin
                    bit_n = bit_q + 1'b1;
                end
            end
            default: state_n = ST_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            slot_q  <= '0;
            bit_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_n;
            slot_q  <= slot_n;
            bit_q   <= bit_n;
            hold_q  <= hold_n;
        end
    end

    // registered link outputs, decoded from the upcoming position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync        <= 1'b0;
            codec_rst_n <= 1'b0;
        end else begin
            codec_rst_n <= (state_n != ST_HOLD);
            unique case (state_n)
                ST_HOLD: sync <= 1'b0;
                ST_LEAD: sync <= 1'b1;
                ST_TAG:  sync <= (bit_n != BIT_W'(TAG_W - 1));
                ST_SLOT: sync <= (slot_n == SLOT_IDX_W'(N_DATA)) &&
                                 (bit_n == BIT_W'(SLOT_W - 1));
                default: sync <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/aclink_tx_ser.sv
module aclink_tx_ser
    import aclink_pkg::*;
#(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int N_DATA = 12,
    localparam int NSLOT      = N_DATA + 1,
    localparam int MAX_W      = (SLOT_W > TAG_W) ? SLOT_W : TAG_W,
    localparam int BIT_W      = $clog2(MAX_W),
    localparam int SLOT_IDX_W = $clog2(N_DATA + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  link_state_t             state_n,
    input  logic [SLOT_IDX_W-1:0]   slot_n,
    input  logic [BIT_W-1:0]        bit_n,
    input  logic [NSLOT*SLOT_W-1:0] tx_words,
    output logic                    sdout
);

    logic [SLOT_W-1:0] tag_word;
    logic [SLOT_W-1:0] load_word;
    logic [SLOT_W-1:0] shreg;
    logic              active;
    logic              load;

    // tag is left-aligned in the shifter so its MSB leaves first
    generate
        if (SLOT_W > TAG_W) begin : g_pad
            assign tag_word = {tx_words[TAG_W-1:0], {(SLOT_W - TAG_W){1'b0}}};
        end else begin : g_nopad
            assign tag_word = tx_words[SLOT_W-1:0];
        end
    endgenerate

    assign active = (state_n == ST_TAG) || (state_n == ST_SLOT);
    assign load   = active && (bit_n == '0);

    always_comb begin
        if (slot_n == '0) begin
            load_word = tag_word;
        end else begin
            load_word = tx_words[int'(slot_n)*SLOT_W +: SLOT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            sdout <= 1'b0;
        end else if (!active) begin
            shreg <= '0;
            sdout <= 1'b0;
        end else if (load) begin
            sdout <= load_word[SLOT_W-1];
            shreg <= {load_word[SLOT_W-2:0], 1'b0};
        end else begin
            sdout <= shreg[SLOT_W-1];
            shreg <= {shreg[SLOT_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/aclink_rx_des.sv
module aclink_rx_des
    import aclink_pkg::*;
#(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int N_DATA = 12,
    localparam int NSLOT      = N_DATA + 1,
    localparam int MAX_W      = (SLOT_W > TAG_W) ? SLOT_W : TAG_W,
    localparam int BIT_W      = $clog2(MAX_W),
    localparam int SLOT_IDX_W = $clog2(N_DATA + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  link_state_t             state_q,
    input  logic [SLOT_IDX_W-1:0]   slot_q,
    input  logic [BIT_W-1:0]        bit_q,
    input  logic                    sdin,
    output logic [NSLOT*SLOT_W-1:0] rx_words,
    output logic                    frame_done
);

    localparam logic [SLOT_W-1:0] TAG_MASK = SLOT_W'((64'd1 << TAG_W) - 64'd1);

    logic [SLOT_W-1:0] shreg;
    logic [SLOT_W-1:0] full_word;
    logic [SLOT_W-1:0] mem [NSLOT];
    logic              in_tag;
    logic              slot_end;
    logic              frame_end;
    logic              cap_last;

    assign in_tag    = (state_q == ST_TAG);
    assign slot_end  = (in_tag && bit_q == BIT_W'(TAG_W - 1)) ||
                       (state_q == ST_SLOT && bit_q == BIT_W'(SLOT_W - 1));
    assign frame_end = (state_q == ST_SLOT) && (slot_q == SLOT_IDX_W'(N_DATA)) &&
                       (bit_q == BIT_W'(SLOT_W - 1));
    assign full_word = {shreg[SLOT_W-2:0], sdin};

    // capture on the falling edge, mid-bit
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            cap_last <= 1'b0;
            for (int i = 0; i < NSLOT; i++) begin
                mem[i] <= '0;
            end
        end else begin
            cap_last <= frame_end;
            if (in_tag || state_q == ST_SLOT) begin
                shreg <= full_word;
                if (slot_end) begin
                    mem[slot_q] <= in_tag ? (full_word & TAG_MASK) : full_word;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
        end else begin
            frame_done <= cap_last;
        end
    end

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_out
            assign rx_words[g*SLOT_W +: SLOT_W] = mem[g];
        end
    endgenerate

endmodule

// File: rtl/aclink_seq.sv
module aclink_seq
    import aclink_pkg::*;
#(
    parameter int TAG_W      = 16,
    parameter int SLOT_W     = 20,
    parameter int N_DATA     = 12,
    parameter int RST_CYCLES = 16,
    localparam int NSLOT      = N_DATA + 1,
    localparam int MAX_W      = (SLOT_W > TAG_W) ? SLOT_W : TAG_W,
    localparam int BIT_W      = $clog2(MAX_W),
    localparam int SLOT_IDX_W = $clog2(N_DATA + 1)
) (
    input  logic                    bclk,
    input  logic                    rst_n,
    input  logic [NSLOT*SLOT_W-1:0] tx_words,
    input  logic                    sdin,
    output logic                    sdout,
    output logic                    sync,
    output logic                    codec_rst_n,
    output logic [NSLOT*SLOT_W-1:0] rx_words,
    output logic                    frame_done
);

    link_state_t           state_q;
    link_state_t           state_n;
    logic [SLOT_IDX_W-1:0] slot_q;
    logic [SLOT_IDX_W-1:0] slot_n;
    logic [BIT_W-1:0]      bit_q;
    logic [BIT_W-1:0]      bit_n;

    aclink_timer #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_DATA(N_DATA), .RST_CYCLES(RST_CYCLES)
    ) u_timer (
        .clk(bclk), .rst_n(rst_n),
        .state_q(state_q), .slot_q(slot_q), .bit_q(bit_q),
        .state_n(state_n), .slot_n(slot_n), .bit_n(bit_n),
        .sync(sync), .codec_rst_n(codec_rst_n)
    );

    aclink_tx_ser #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_DATA(N_DATA)
    ) u_tx (
        .clk(bclk), .rst_n(rst_n),
        .state_n(state_n), .slot_n(slot_n), .bit_n(bit_n),
        .tx_words(tx_words), .sdout(sdout)
    );

    aclink_rx_des #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_DATA(N_DATA)
    ) u_rx (
        .clk(bclk), .rst_n(rst_n),
        .state_q(state_q), .slot_q(slot_q), .bit_q(bit_q),
        .sdin(sdin), .rx_words(rx_words), .frame_done(frame_done)
    );

endmodule

// File: rtl/aclink_seq_chk.sv
module aclink_seq_chk #(
    parameter int TAG_W  = 16,
    parameter int SLOT_W = 20,
    parameter int N_DATA = 12,
    localparam int FRAME_LEN = TAG_W + N_DATA * SLOT_W
) (
    input logic bclk,
    input logic rst_n,
    input logic sdout,
    input logic sync,
    input logic codec_rst_n,
    input logic frame_done
);

    logic [15:0] run;
    logic [15:0] gap;
    logic        sync_d;
    logic        seen;
    logic        rise;

    assign rise = sync && !sync_d;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            run    <= '0;
            gap    <= '0;
            sync_d <= 1'b0;
            seen   <= 1'b0;
        end else begin
            run    <= sync ? run + 16'd1 : 16'd0;
            sync_d <= sync;
            if (rise) begin
                gap  <= 16'd1;
                seen <= 1'b1;
            end else begin
                gap <= gap + 16'd1;
            end
        end
    end

    p_quiet_in_hold_r2: assert property (@(posedge bclk) disable iff (!rst_n)
        !codec_rst_n |-> (!sync && !sdout && !frame_done));

    p_codec_rst_sticky_r2: assert property (@(posedge bclk) disable iff (!rst_n)
        codec_rst_n |=> codec_rst_n);

    p_frame_period_r3: assert property (@(posedge bclk) disable iff (!rst_n)
        (rise && seen) |-> (gap == 16'(FRAME_LEN)));

    p_sync_width_r4: assert property (@(posedge bclk) disable iff (!rst_n)
        $fell(sync) |-> (run == 16'(TAG_W)));

    p_done_pulse_r8: assert property (@(posedge bclk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    p_done_in_sync_r8: assert property (@(posedge bclk) disable iff (!rst_n)
        frame_done |-> sync);

endmodule

bind aclink_seq aclink_seq_chk #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_DATA(N_DATA)
) u_chk (
    .bclk(bclk), .rst_n(rst_n), .sdout(sdout), .sync(sync),
    .codec_rst_n(codec_rst_n), .frame_done(frame_done)
);

// File: tb/sim_aclink_seq.sv
module sim_aclink_seq;

    localparam int TAG_W      = 16;
    localparam int SLOT_W     = 20;
    localparam int N_DATA     = 12;
    localparam int NSLOT      = N_DATA + 1;
    localparam int FRAME      = TAG_W + N_DATA * SLOT_W;
    localparam int RST_CYCLES = 16;
    localparam int WW         = NSLOT * SLOT_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [WW-1:0] tx_words = '0;
    logic          sdin = 1'b0;
    logic          sdout;
    logic          sync;
    logic          codec_rst_n;
    logic [WW-1:0] rx_words;
    logic          frame_done;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic sd;
        logic sy;
        logic fd;
        int   pos;
    } exp_t;

    exp_t          exp_q[$];
    logic [WW-1:0] rx_q[$];
    exp_t          em;
    logic [WW-1:0] rx_exp;

    always #10 clk = ~clk;

    aclink_seq #(
        .TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_DATA(N_DATA), .RST_CYCLES(RST_CYCLES)
    ) u0 (
        .bclk(clk), .rst_n(rst_n), .tx_words(tx_words), .sdin(sdin),
        .sdout(sdout), .sync(sync), .codec_rst_n(codec_rst_n),
        .rx_words(rx_words), .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic frame_bit(input logic [WW-1:0] w, input int b);
        if (b < TAG_W) begin
            return w[TAG_W-1-b];
        end else begin
            int k = (b - TAG_W) / SLOT_W + 1;
            int j = (b - TAG_W) % SLOT_W;
            return w[k*SLOT_W + SLOT_W-1-j];
        end
    endfunction

    function automatic logic [WW-1:0] mk(input int kind, input int seed);
        logic [WW-1:0] w = '0;
        for (int k = 0; k < NSLOT; k++) begin
            logic [SLOT_W-1:0] v;
            case (kind)
                0:       v = SLOT_W'(k * 32'h01357 + seed);
                1:       v = (k % 2 == 1) ? 20'hAAAAA : 20'h55555;
                2:       v = SLOT_W'(32'd1 << ((k + seed) % SLOT_W));
                default: v = 20'hFFFFF;
            endcase
            w[k*SLOT_W +: SLOT_W] = v;
        end
        // upper tag-field bits set non-zero: must be ignored (R5, R7)
        w[SLOT_W-1:TAG_W] = 4'hD;
        return w;
    endfunction

    // driver: one item pushed per bit, sdin driven for that bit
    task automatic run_frame(input logic [WW-1:0] txw, input logic [WW-1:0] rxw,
                             input bit first, input int stop_at);
        tx_words = txw;
        for (int b = 0; b < stop_at; b++) begin
            exp_t e;
            @(posedge clk);
            #2;
            sdin = frame_bit(rxw, b);
            e.sd  = frame_bit(txw, b);
            e.sy  = (b < TAG_W - 1) || (b == FRAME - 1);
            e.fd  = (b == 0) && !first;
            e.pos = b;
            exp_q.push_back(e);
        end
        if (stop_at == FRAME) begin
            logic [WW-1:0] m = rxw;
            m[SLOT_W-1:TAG_W] = '0;
            rx_q.push_back(m);
        end
    endtask

    // monitor: pops and compares as the design produces each bit
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            em = exp_q.pop_front();
            chk(sdout === em.sd, (em.pos < TAG_W) ? "R5" : "R6", "sdout bit",
                32'(sdout), 32'(em.sd));
            chk(sync === em.sy, "R4", "sync bit", 32'(sync), 32'(em.sy));
            chk(frame_done === em.fd, "R8", "frame_done", 32'(frame_done), 32'(em.fd));
            if (frame_done === 1'b1 && em.fd) begin
                if (rx_q.size() == 0) begin
                    chk(1'b0, "R8", "strobe with nothing pending", 32'd1, 32'd0);
                end else begin
                    rx_exp = rx_q.pop_front();
                    for (int k = 0; k < NSLOT; k++) begin
                        chk(rx_words[k*SLOT_W +: SLOT_W] === rx_exp[k*SLOT_W +: SLOT_W],
                            "R7", $sformatf("rx slot %0d", k),
                            32'(rx_words[k*SLOT_W +: SLOT_W]),
                            32'(rx_exp[k*SLOT_W +: SLOT_W]));
                    end
                end
            end
        end
    end

    task automatic hold_phase();
        for (int i = 1; i <= RST_CYCLES; i++) begin
            @(posedge clk);
            #5;
            chk(codec_rst_n === (i == RST_CYCLES), "R2", $sformatf("codec_rst_n edge %0d", i),
                32'(codec_rst_n), 32'(i == RST_CYCLES));
            chk(sync === (i == RST_CYCLES), "R4", $sformatf("lead-in sync edge %0d", i),
                32'(sync), 32'(i == RST_CYCLES));
            chk(sdout === 1'b0, "R4", "sdout in hold/lead", 32'(sdout), 32'd0);
        end
    endtask

    task automatic reset_checks(input string req);
        chk(sdout === 1'b0, req, "sdout in reset", 32'(sdout), 32'd0);
        chk(sync === 1'b0, req, "sync in reset", 32'(sync), 32'd0);
        chk(codec_rst_n === 1'b0, req, "codec_rst_n in reset", 32'(codec_rst_n), 32'd0);
        chk(frame_done === 1'b0, req, "frame_done in reset", 32'(frame_done), 32'd0);
        chk(rx_words === '0, req, "rx_words in reset", 32'(rx_words[31:0]), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #5;
        reset_checks("R1");
        @(posedge clk);
        #7;
        rst_n = 1'b1;
        hold_phase();

        // back-to-back frames, R3/R5/R6/R7/R8
        run_frame(mk(0, 32'h10), mk(0, 32'h2B), 1'b1, FRAME);
        run_frame(mk(1, 0), mk(2, 3), 1'b0, FRAME);
        run_frame(mk(2, 0), mk(1, 0), 1'b0, FRAME);
        run_frame(mk(3, 0), mk(3, 0), 1'b0, 100);

        // R9: reset in the middle of a frame
        #5;
        rst_n = 1'b0;
        repeat (2) begin
            @(posedge clk);
            #5;
            reset_checks("R9");
        end
        @(posedge clk);
        #7;
        rst_n = 1'b1;
        hold_phase();
        run_frame(mk(0, 32'h777), mk(2, 7), 1'b1, FRAME);
        run_frame(mk(1, 0), mk(1, 0), 1'b0, 1);

        repeat (4) @(posedge clk);
        #5;
        chk(rx_q.size() == 0, "R8", "undelivered frames", 32'(rx_q.size()), 32'd0);
        chk(frame_done === 1'b0, "R8", "frame_done idle", 32'(frame_done), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule